// File: doc/BRIEF.md
# UART Line Control and Baud Divisor Bank

This block holds the line settings of an asynchronous serial port and the baud-rate divisor, and turns the applied divisor into a sampling tick for the transmitter and receiver. A host reaches it over a byte-wide register bus with a 3-bit offset, a write strobe and a read strobe. The line control byte is at offset 3. Its top bit opens a bank. While that bank bit is set, offsets 0 and 1 reach the low and high bytes of a staged divisor. While it is clear, those offsets belong to the data and interrupt-enable registers that sit outside this block, and the block ignores them.

The line control byte is decoded continuously into configuration outputs: data-bit count, stop-bit count, parity mode and a break request. A staged divisor becomes active only when a line control write moves the bank bit from 1 to 0, and only if the staged value is nonzero. Software can therefore rewrite both divisor bytes without the rate passing through a half-updated value.

The tick generator is a two-state machine. TK_STOP is the state after reset, where no divisor has been applied. TK_RUN counts pulses of the reference enable, which nominally runs at 16 times 115200 Hz, and emits a one-cycle tick every D enables, where D is the active divisor. The transition TK_STOP to TK_RUN happens on the first applied divisor. The transition TK_RUN to TK_RUN on an apply reloads the counter. There is no return to TK_STOP except through reset.

Top module: `uart_line_ctl`

## Requirements
- R1: After reset the line control byte reads 0, the active divisor is 0, the word length output is 5, one stop bit, parity code 0, no break, and no tick is ever emitted while the active divisor is 0.
- R2: A write to offset 3 stores all 8 bits of the line control byte, and a read of offset 3 returns them.
- R3: While line-control bit 7 is 1, offset 0 reads and writes the staged divisor low byte and offset 1 the high byte. While bit 7 is 0, writes to offsets 0 and 1 leave the staged divisor unchanged and reads of them return 0. Reads of offsets 2 and 4 to 7 always return 0.
- R4: The word length output equals line-control bits [1:0] plus 5, a value from 5 to 8.
- R5: The stop output is 1 (two stop bits) exactly when line-control bit 2 is 1.
- R6: The parity code output is 0 (none) when bit 3 is 0. When bit 3 is 1, the code is taken from bits {5,4}: 00 gives 1 (odd), 01 gives 2 (even), 10 gives 3 (mark) and 11 gives 4 (space).
- R7: The break output equals line-control bit 6.
- R8: The active divisor changes only on a write to offset 3 that clears bit 7 while bit 7 was set. It then takes the staged value. Writes that keep bit 7 at 1, or keep it at 0, do not change it.
- R9: A staged divisor of 0 is never applied. The previous active divisor, and the stopped or running state, remain as they were.
- R10: With active divisor D, the tick output is a one-cycle pulse after every D-th reference enable. Counting restarts from zero after each apply, with the first enable that follows the applying write.
- R11: No tick is produced in a cycle whose edge did not consume a reference enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, qualifies rd_data |
| addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational, zero when rd_en is low |
| ref_en | input | 1 | Reference clock enable (16 x 115200 Hz nominal) |
| divisor_o | output | 16 | Active divisor |
| word_len_o | output | 4 | Data bits per character, 5 to 8 |
| two_stop_o | output | 1 | 1 selects two stop bits |
| parity_o | output | 3 | Parity code: 0 none, 1 odd, 2 even, 3 mark, 4 space |
| break_o | output | 1 | Force break on the transmit line |
| tick_o | output | 1 | 16x baud sampling tick |

## Verification
The bench builds the block with its default 8-bit bus, so the divisor spans 16 bits and every line control code from 0 to 127 can be swept exhaustively through the decoders. Short divisors from 1 to 9 keep tick periods to a few cycles, so many periods can be measured under random enable densities. A divisor of 256 checks that the high byte feeds the counter. Larger staged values such as 0x1234 are used only to check banking and the apply rule, where the exact bit pattern matters.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } parity_e;

    typedef enum logic [0:0] {
        TK_STOP = 1'b0,
        TK_RUN  = 1'b1
    } tk_state_e;

    // bit positions inside the line control byte
    localparam int WL_LSB    = 0;
    localparam int STOP_BIT  = 2;
    localparam int PEN_BIT   = 3;
    localparam int PSEL0_BIT = 4;
    localparam int PSEL1_BIT = 5;
    localparam int BRK_BIT   = 6;

    localparam int MIN_WORD_LEN = 5;

endpackage

// File: rtl/uart_lc_decode.sv
module uart_lc_decode
    import uart_lc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WLEN_W = 4
) (
    input  logic [DATA_W-1:0] lcr,
    output logic [WLEN_W-1:0] word_len,
    output logic              two_stop,
    output parity_e           parity,
    output logic              brk
);

    logic [1:0] wl_code;
    logic [1:0] psel;

    assign wl_code  = lcr[WL_LSB +: 2];
    assign word_len = WLEN_W'(wl_code) + WLEN_W'(MIN_WORD_LEN);
    assign two_stop = lcr[STOP_BIT];
    assign brk      = lcr[BRK_BIT];
    assign psel     = {lcr[PSEL1_BIT], lcr[PSEL0_BIT]};

    always_comb begin
        parity = PAR_NONE;
        if (lcr[PEN_BIT]) begin
            unique case (psel)
                2'b00: parity = PAR_ODD;
                2'b01: parity = PAR_EVEN;
                2'b10: parity = PAR_MARK;
                2'b11: parity = PAR_SPACE;
            endcase
        end
    end

endmodule

// File: rtl/uart_lc_regs.sv
module uart_lc_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] lcr_o,
    output logic [DIV_W-1:0]  div_act_o,
    output logic              apply_o,
    output logic [DIV_W-1:0]  div_new_o
);

    localparam logic [ADDR_W-1:0] OFF_DIV_LO = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_DIV_HI = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_LCR    = ADDR_W'(3);
    localparam int                BANK_BIT   = DATA_W - 1;

    logic [DATA_W-1:0] lcr_q;
    logic [DATA_W-1:0] div_lo_q;
    logic [DATA_W-1:0] div_hi_q;
    logic [DIV_W-1:0]  div_act_q;
    logic [DIV_W-1:0]  staged;
    logic              bank_open;
    logic              wr_lcr;
    logic              wr_lo;
    logic              wr_hi;

    assign bank_open = lcr_q[BANK_BIT];
    assign staged    = {div_hi_q, div_lo_q};
    assign wr_lcr    = wr_en && (addr == OFF_LCR);
    assign wr_lo     = wr_en && bank_open && (addr == OFF_DIV_LO);
    assign wr_hi     = wr_en && bank_open && (addr == OFF_DIV_HI);
    // closing the bank with a nonzero staged value commits it
    assign apply_o   = wr_lcr && bank_open && !wr_data[BANK_BIT] && (staged != '0);
    assign div_new_o = staged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q     <= '0;
            div_lo_q  <= '0;
            div_hi_q  <= '0;
            div_act_q <= '0;
        end else begin
            if (wr_lcr)  lcr_q     <= wr_data;
            if (wr_lo)   div_lo_q  <= wr_data;
            if (wr_hi)   div_hi_q  <= wr_data;
            if (apply_o) div_act_q <= staged;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (addr == OFF_LCR)
                rd_data = lcr_q;
            else if (bank_open && (addr == OFF_DIV_LO))
                rd_data = div_lo_q;
            else if (bank_open && (addr == OFF_DIV_HI))
                rd_data = div_hi_q;
        end
    end

    assign lcr_o     = lcr_q;
    assign div_act_o = div_act_q;

endmodule

// File: rtl/uart_lc_tickgen.sv
module uart_lc_tickgen
    import uart_lc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             apply,
    input  logic [DIV_W-1:0] div_new,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] CNT_LAST = DIV_W'(1);

    tk_state_e        state_q;
    tk_state_e        state_d;
    logic [DIV_W-1:0] reload_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_STOP: if (apply) state_d = TK_RUN;
            TK_RUN:  state_d = TK_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TK_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            tick_q   <= 1'b0;
        end else if (apply) begin
            reload_q <= div_new;
            cnt_q    <= div_new;
            tick_q   <= 1'b0;
        end else if ((state_q == TK_RUN) && ref_en) begin
            if (cnt_q <= CNT_LAST) begin
                cnt_q  <= reload_q;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q - CNT_LAST;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/uart_line_ctl.sv
module uart_line_ctl
    import uart_lc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int WLEN_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                ref_en,
    output logic [2*DATA_W-1:0] divisor_o,
    output logic [WLEN_W-1:0]   word_len_o,
    output logic                two_stop_o,
    output logic [2:0]          parity_o,
    output logic                break_o,
    output logic                tick_o
);

    localparam int DIV_W = 2 * DATA_W;

    logic [DATA_W-1:0] lcr;
    logic [DIV_W-1:0]  div_new;
    logic              apply;
    parity_e           parity;

    uart_lc_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .DIV_W (DIV_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .lcr_o    (lcr),
        .div_act_o(divisor_o),
        .apply_o  (apply),
        .div_new_o(div_new)
    );

    uart_lc_decode #(
        .DATA_W(DATA_W),
        .WLEN_W(WLEN_W)
    ) u_decode (
        .lcr     (lcr),
        .word_len(word_len_o),
        .two_stop(two_stop_o),
        .parity  (parity),
        .brk     (break_o)
    );

    uart_lc_tickgen #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_en (ref_en),
        .apply  (apply),
        .div_new(div_new),
        .tick_o (tick_o)
    );

    assign parity_o = parity;

endmodule

// File: rtl/uart_line_ctl_checker.sv
module uart_line_ctl_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int WLEN_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                ref_en,
    input logic [2*DATA_W-1:0] divisor_o,
    input logic [WLEN_W-1:0]   word_len_o,
    input logic [2:0]          parity_o,
    input logic                tick_o
);

    localparam logic [ADDR_W-1:0] OFF_LCR = ADDR_W'(3);

    assert_wlen_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_len_o >= WLEN_W'(5)) && (word_len_o <= WLEN_W'(8)));

    assert_parity_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        parity_o <= 3'd4);

    assert_div_only_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_o != $past(divisor_o)) |->
            $past(wr_en && (addr == OFF_LCR) && !wr_data[DATA_W-1]));

    assert_zero_not_applied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_o != $past(divisor_o)) |-> (divisor_o != '0));

    assert_tick_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(ref_en));

    assert_no_tick_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_o == '0) |-> !tick_o);

endmodule

bind uart_line_ctl uart_line_ctl_checker #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .WLEN_W(WLEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .ref_en    (ref_en),
    .divisor_o (divisor_o),
    .word_len_o(word_len_o),
    .parity_o  (parity_o),
    .tick_o    (tick_o)
);

// File: tb/uart_line_ctl_bench.sv
module uart_line_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        ref_en = 1'b0;
    logic [15:0] divisor_o;
    logic [3:0]  word_len_o;
    logic        two_stop_o;
    logic [2:0]  parity_o;
    logic        break_o;
    logic        tick_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_line_ctl u_uart_line_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ref_en    (ref_en),
        .divisor_o (divisor_o),
        .word_len_o(word_len_o),
        .two_stop_o(two_stop_o),
        .parity_o  (parity_o),
        .break_o   (break_o),
        .tick_o    (tick_o)
    );

    function automatic logic [2:0] exp_parity(input logic [7:0] l);
        if (!l[3])                 return 3'd0;
        else if (!l[5] && !l[4])   return 3'd1;
        else if (!l[5] &&  l[4])   return 3'd2;
        else if ( l[5] && !l[4])   return 3'd3;
        else                       return 3'd4;
    endfunction

    function automatic logic [3:0] exp_wlen(input logic [7:0] l);
        return 4'(l[1:0]) + 4'd5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic check_decode(input logic [7:0] l);
        chk("R4 word length", 32'(word_len_o), 32'(exp_wlen(l)));
        chk("R5 stop bits",   32'(two_stop_o), 32'(l[2]));
        chk("R6 parity code", 32'(parity_o),   32'(exp_parity(l)));
        chk("R7 break",       32'(break_o),    32'(l[6]));
    endtask

    task automatic set_divisor(input logic [15:0] d);
        bus_write(3'd3, 8'h80);
        bus_write(3'd0, d[7:0]);
        bus_write(3'd1, d[15:8]);
        bus_write(3'd3, 8'h03);
    endtask

    // R10: one tick per d consumed enables, enable density in percent
    task automatic measure(input int d, input int nticks, input int dense);
        int en_cnt = 0;
        int got = 0;
        int guard = 0;
        while (got < nticks && guard < d * nticks * 20 + 200) begin
            @(negedge clk);
            guard++;
            if (tick_o) begin
                chk("R10 enables per tick", 32'(en_cnt), 32'(d));
                en_cnt = 0;
                got++;
            end
            ref_en = ($urandom_range(0, 99) < dense);
            if (ref_en) en_cnt++;
        end
        @(negedge clk);
        ref_en = 1'b0;
        chk("R10 tick count reached", 32'(got), 32'(nticks));
    endtask

    task automatic count_ticks(input int cycles, input logic en, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            ref_en = en;
            if (tick_o) n++;
        end
        @(negedge clk);
        if (tick_o) n++;
        ref_en = 1'b0;
    endtask

    initial begin : watchdog
        #1600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        int         n;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 divisor", 32'(divisor_o), 32'h0);
        check_decode(8'h00);
        bus_read(3'd3, rd);
        chk("R1 lcr reads 0", 32'(rd), 32'h0);
        count_ticks(60, 1'b1, n);
        chk("R1 no tick while stopped", 32'(n), 32'd0);

        // R2 R4 R5 R6 R7 exhaustive sweep over bank-clear codes
        for (int c = 0; c < 128; c++) begin
            bus_write(3'd3, 8'(c));
            check_decode(8'(c));
            bus_read(3'd3, rd);
            chk("R2 lcr readback", 32'(rd), 32'(c));
        end

        // R3 banking
        bus_write(3'd3, 8'hC5);
        check_decode(8'hC5);
        bus_write(3'd0, 8'h34);
        bus_write(3'd1, 8'h12);
        bus_read(3'd0, rd);
        chk("R3 staged low byte", 32'(rd), 32'h34);
        bus_read(3'd1, rd);
        chk("R3 staged high byte", 32'(rd), 32'h12);
        bus_read(3'd2, rd);
        chk("R3 offset 2 reads 0", 32'(rd), 32'h0);
        chk("R8 no apply while open", 32'(divisor_o), 32'h0);
        bus_write(3'd3, 8'h83);
        chk("R8 bank kept open", 32'(divisor_o), 32'h0);
        bus_write(3'd3, 8'h03);
        chk("R8 apply on close", 32'(divisor_o), 32'h1234);
        bus_write(3'd0, 8'hFF);
        bus_write(3'd1, 8'hEE);
        bus_read(3'd0, rd);
        chk("R3 closed offset 0 reads 0", 32'(rd), 32'h0);
        bus_write(3'd3, 8'h07);
        chk("R8 closed write no apply", 32'(divisor_o), 32'h1234);
        bus_write(3'd3, 8'h80);
        bus_read(3'd0, rd);
        chk("R3 closed write ignored lo", 32'(rd), 32'h34);
        bus_read(3'd1, rd);
        chk("R3 closed write ignored hi", 32'(rd), 32'h12);

        // R9 zero staged value ignored
        bus_write(3'd0, 8'h00);
        bus_write(3'd1, 8'h00);
        bus_write(3'd3, 8'h00);
        chk("R9 zero keeps divisor", 32'(divisor_o), 32'h1234);

        // R10 directed periods
        set_divisor(16'd1);
        chk("R8 divisor 1", 32'(divisor_o), 32'd1);
        measure(1, 10, 100);
        set_divisor(16'd3);
        measure(3, 8, 100);
        set_divisor(16'd256);
        chk("R8 divisor 256", 32'(divisor_o), 32'd256);
        measure(256, 3, 100);

        // R9 zero while running keeps ticking at old rate
        set_divisor(16'd0);
        chk("R9 zero while running", 32'(divisor_o), 32'd256);
        set_divisor(16'd5);
        measure(5, 5, 100);

        // R11 no enables, no ticks
        count_ticks(40, 1'b0, n);
        chk("R11 no tick without enable", 32'(n), 32'd0);

        // R10 random divisors and enable densities
        for (int k = 0; k < 12; k++) begin
            int d;
            int dn;
            d  = $urandom_range(1, 9);
            dn = $urandom_range(20, 100);
            set_divisor(16'(d));
            chk("R8 random divisor", 32'(divisor_o), 32'(d));
            measure(d, 6, dn);
        end

        // random line control writes
        for (int k = 0; k < 30; k++) begin
            logic [7:0] v;
            v = 8'($urandom_range(0, 127));
            bus_write(3'd3, v);
            check_decode(v);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule